// File: doc/BRIEF.md
# GPIO Bank Direction and Data Control

This block holds the data, per-pin direction and bank-mode registers for twenty general-purpose pins. The pins form two banks: a narrow bank of pins 7:0 and a wide bank of pins 19:8. For every pin it drives an output-enable and an output value toward an open-drain style pad. It also brings the pad input levels through a two-flop synchroniser so that they can be read back. It sits behind a plain register bus: one address, write data with a write strobe, and a read strobe that returns registered read data on the next cycle.

Each bank can run in one of two modes. In pull-up mode the data bit alone sets the pin: a 0 pulls the pin low and a 1 releases it to high impedance, where it acts as an input. In direction-register mode a separate per-pin direction bit enables the driver, and the data bit is the value driven. A write strobe stands for the acknowledge of the byte on the serial side, so new pad values appear only after the clock edge that takes the write.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, data and direction registers hold 1 in every valid bit, the mode register holds 03h, and every `pad_oe` bit is 0.
- R2: A write to address 00h, 01h or 02h stores `wr_data` into the data bits of pins 7:0, 15:8 or 19:16. At 02h (and at the matching direction address 08h) `wr_data[7:4]` is ignored. A write to 09h keeps only `wr_data[1:0]`.
- R3: Reads of 06h, 07h, 08h return the direction bits of pins 7:0, 15:8, 19:16, and a read of 09h returns the mode bits. Reads of 02h and 08h return 0 in bits 7:4, and a read of 09h returns 0 in bits 7:2.
- R4: In pull-up mode a pin with data bit 0 has `pad_oe`=1 and `pad_out`=0, and a pin with data bit 1 has `pad_oe`=0 and `pad_out`=0.
- R5: In direction-register mode `pad_oe` is the inverse of the pin's direction bit (0 = output, 1 = input), and `pad_out` equals the pin's data bit.
- R6: Mode bit 0 (1 = pull-up, 0 = direction register) governs pins 7:0 alone. Mode bit 1 governs pins 19:8 alone.
- R7: `pad_oe` and `pad_out` change only on the clock edge that samples `wr_en` high. Their new values are visible from that edge on, and they are stable in every other cycle.
- R8: A read of 00h, 01h or 02h loads `rd_data` on the edge that samples `rd_en` with the synchronised levels of the lane's pins. A pin level must be present for two edges before the read edge to be seen. `rd_data` holds between reads.
- R9: Addresses 03h to 05h and 0Ah to 0Fh hold no state: writes there change nothing, and reads return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rd_data | output | 8 | Read data, loaded on the edge that samples `rd_en` |
| pad_in | input | 20 | Pad input levels, asynchronous |
| pad_oe | output | 20 | Per-pin driver enable |
| pad_out | output | 20 | Per-pin driven value |

## Verification
A wrong data, direction or mode bit shows at once on `pad_oe` or `pad_out` for the pins it governs, starting on the cycle after the write that should have set it. So every write in the stimulus table is followed by a comparison of all forty pad outputs. A decode fault that mixes up lanes or banks shows up as the wrong pins changing. An error in read capture or synchroniser depth shows in `rd_data` on the cycle after a read strobe, and the bench brackets it with reads one and two edges too early and then exactly on time.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int LANE_W     = 2;
    localparam int LANE_SLOTS = 3;
    localparam int MODE_W     = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [LANE_W-1:0] lane_t;

    // Address map: byte lanes of data, a reserved window, then direction lanes and the mode byte.
    localparam int DATA_BASE = 0;
    localparam int HOLE_BASE = DATA_BASE + LANE_SLOTS;
    localparam int DIR_BASE  = HOLE_BASE + LANE_SLOTS;
    localparam int MODE_ADDR = DIR_BASE + LANE_SLOTS;

    // Per-bank drive policy, as held in each mode bit.
    typedef enum logic {
        BANK_DIRREG = 1'b0,
        BANK_PULLUP = 1'b1
    } bank_mode_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_MODE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        lane_t    lane;
    } dec_t;

    function automatic dec_t decode_addr(addr_t a, int lanes);
        dec_t d;
        int   ai;
        ai     = int'(a);
        d.sel  = SEL_NONE;
        d.lane = '0;
        if (ai >= DATA_BASE && ai < DATA_BASE + lanes) begin
            d.sel  = SEL_DATA;
            d.lane = lane_t'(ai - DATA_BASE);
        end else if (ai >= DIR_BASE && ai < DIR_BASE + lanes) begin
            d.sel  = SEL_DIR;
            d.lane = lane_t'(ai - DIR_BASE);
        end else if (ai == MODE_ADDR) begin
            d.sel  = SEL_MODE;
        end
        return d;
    endfunction

    function automatic int lane_width(int lane, int pins);
        int rest;
        rest = pins - lane * BYTE_W;
        return (rest < BYTE_W) ? rest : BYTE_W;
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int NUM_PINS = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  dec_t                dec,
    input  byte_t               wr_data,
    output logic [NUM_PINS-1:0] data_q,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [MODE_W-1:0]   mode_q
);
    localparam int LANES = (NUM_PINS + BYTE_W - 1) / BYTE_W;

    logic [NUM_PINS-1:0] data_d;
    logic [NUM_PINS-1:0] dir_d;
    logic [MODE_W-1:0]   mode_d;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int LO = i * BYTE_W;
        localparam int LW = lane_width(i, NUM_PINS);
        logic hit_data;
        logic hit_dir;
        assign hit_data = wr_en && (dec.sel == SEL_DATA) && (dec.lane == lane_t'(i));
        assign hit_dir  = wr_en && (dec.sel == SEL_DIR)  && (dec.lane == lane_t'(i));
        // Narrow lanes take only the low bits of the write byte.
        assign data_d[LO +: LW] = hit_data ? wr_data[LW-1:0] : data_q[LO +: LW];
        assign dir_d[LO +: LW]  = hit_dir  ? wr_data[LW-1:0] : dir_q[LO +: LW];
    end

    assign mode_d = (wr_en && dec.sel == SEL_MODE) ? wr_data[MODE_W-1:0] : mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '1;
            dir_q  <= '1;
            mode_q <= '1;
        end else begin
            data_q <= data_d;
            dir_q  <= dir_d;
            mode_q <= mode_d;
        end
    end
endmodule

// File: rtl/gpx_pad_ctrl.sv
module gpx_pad_ctrl
    import gpx_pkg::*;
#(
    parameter int NUM_PINS = 20,
    parameter int LO_W     = 8
) (
    input  logic [NUM_PINS-1:0] data_q,
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [MODE_W-1:0]   mode_q,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int BANK = (p < LO_W) ? 0 : 1;
        bank_mode_e mode;
        assign mode = bank_mode_e'(mode_q[BANK]);
        always_comb begin
            if (mode == BANK_PULLUP) begin
                pad_oe[p]  = ~data_q[p];
                pad_out[p] = 1'b0;
            end else begin
                pad_oe[p]  = ~dir_q[p];
                pad_out[p] = data_q[p];
            end
        end
    end
endmodule

// File: rtl/gpx_rdmux.sv
module gpx_rdmux
    import gpx_pkg::*;
#(
    parameter int NUM_PINS = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  dec_t                dec,
    input  logic [NUM_PINS-1:0] pin_sync,
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [MODE_W-1:0]   mode_q,
    output byte_t               rd_data
);
    localparam int LANES = (NUM_PINS + BYTE_W - 1) / BYTE_W;

    byte_t pin_lane [LANES];
    byte_t dir_lane [LANES];
    byte_t rd_next;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int LO = i * BYTE_W;
        localparam int LW = lane_width(i, NUM_PINS);
        assign pin_lane[i] = BYTE_W'(pin_sync[LO +: LW]);
        assign dir_lane[i] = BYTE_W'(dir_q[LO +: LW]);
    end

    always_comb begin
        rd_next = '0;
        case (dec.sel)
            SEL_DATA: if (int'(dec.lane) < LANES) rd_next = pin_lane[dec.lane];
            SEL_DIR:  if (int'(dec.lane) < LANES) rd_next = dir_lane[dec.lane];
            SEL_MODE: rd_next = BYTE_W'(mode_q);
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpx_pkg::*;
#(
    parameter int NUM_PINS = 20,
    parameter int LO_W     = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [BYTE_W-1:0]   rd_data,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out
);
    localparam int LANES = (NUM_PINS + BYTE_W - 1) / BYTE_W;

    dec_t                dec;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] data_q;
    logic [NUM_PINS-1:0] dir_q;
    logic [MODE_W-1:0]   mode_q;

    assign dec = decode_addr(addr, LANES);

    gpx_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpx_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .dec     (dec),
        .wr_data (wr_data),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .mode_q  (mode_q)
    );

    gpx_pad_ctrl #(.NUM_PINS(NUM_PINS), .LO_W(LO_W)) u_pads (
        .data_q  (data_q),
        .dir_q   (dir_q),
        .mode_q  (mode_q),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    gpx_rdmux #(.NUM_PINS(NUM_PINS)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .dec      (dec),
        .pin_sync (pin_sync),
        .dir_q    (dir_q),
        .mode_q   (mode_q),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
    parameter int NUM_PINS = 20,
    parameter int LO_W     = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [3:0]          addr,
    input logic                wr_en,
    input logic                rd_en,
    input logic [7:0]          rd_data,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [1:0]          mode_q
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0)); // R1

    AST_NARROW_READ: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && ($past(addr) == 4'h2 || $past(addr) == 4'h8)) |-> (rd_data[7:4] == 4'h0)); // R3

    AST_PULLUP_LO_LOW: assert property (@(posedge clk) disable iff (rst)
        mode_q[0] |-> (pad_out[LO_W-1:0] == '0)); // R4

    AST_PULLUP_HI_LOW: assert property (@(posedge clk) disable iff (rst)
        mode_q[1] |-> (pad_out[NUM_PINS-1:LO_W] == '0)); // R4

    AST_PAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> ($stable(pad_oe) && $stable(pad_out))); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> $stable(rd_data)); // R8

    AST_HOLE_READ: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && (($past(addr) >= 4'h3 && $past(addr) <= 4'h5) || $past(addr) >= 4'hA))
        |-> (rd_data == 8'h00)); // R9
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS), .LO_W(LO_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .mode_q  (mode_q)
);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [19:0] pad_in = '0;
    logic [19:0] pad_oe;
    logic [19:0] pad_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    gpio_bank_ctrl dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    // {addr, wdata, expected pad_oe, expected pad_out} after each write
    localparam int NV = 12;
    localparam logic [51:0] VEC [NV] = '{
        {4'h0, 8'hA5, 20'h0005A, 20'h00000},  // R2 R4 low bank pull-up
        {4'h2, 8'hF3, 20'hC005A, 20'h00000},  // R2 upper nibble dropped
        {4'h9, 8'h02, 20'hC0000, 20'h000A5},  // R5 R6 low bank to direction mode
        {4'h6, 8'h0F, 20'hC00F0, 20'h000A5},  // R5
        {4'h9, 8'h00, 20'h000F0, 20'h3FFA5},  // R6 both banks direction mode
        {4'h8, 8'hA6, 20'h900F0, 20'h3FFA5},  // R2 R5 narrow direction lane
        {4'h1, 8'h3C, 20'h900F0, 20'h33CA5},  // R2 R5
        {4'h4, 8'h00, 20'h900F0, 20'h33CA5},  // R9 reserved address
        {4'hB, 8'h00, 20'h900F0, 20'h33CA5},  // R9 beyond mode address
        {4'h7, 8'h00, 20'h9FFF0, 20'h33CA5},  // R5
        {4'h9, 8'h01, 20'h9FF5A, 20'h33C00},  // R6 low pull-up, high direction
        {4'h9, 8'hFE, 20'hCC3F0, 20'h000A5}   // R2 R6 mode keeps bits 1:0
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pad_oe after reset", 32'(pad_oe), 32'h0);
        check("R1 pad_out after reset", 32'(pad_out), 32'h0);
        rd(4'h9, r); check("R1 mode reset", 32'(r), 32'h03);
        rd(4'h7, r); check("R1 dir 15:8 reset", 32'(r), 32'hFF);
        rd(4'h8, r); check("R1 R3 dir 19:16 reset", 32'(r), 32'h0F);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][51:48], VEC[i][47:40]);
            check($sformatf("R2 R4 R5 R6 vector %0d oe", i), 32'(pad_oe), 32'(VEC[i][39:20]));
            check($sformatf("R2 R4 R5 R6 vector %0d out", i), 32'(pad_out), 32'(VEC[i][19:0]));
        end

        rd(4'h8, r); check("R3 dir 19:16 upper zero", 32'(r), 32'h06);
        rd(4'h6, r); check("R3 dir 7:0 readback", 32'(r), 32'h0F);
        rd(4'h9, r); check("R3 mode readback", 32'(r), 32'h02);
        rd(4'h4, r); check("R9 read reserved", 32'(r), 32'h00);
        rd(4'hC, r); check("R9 read beyond map", 32'(r), 32'h00);

        // R7: pads hold until the edge that takes the write
        @(negedge clk);
        addr = 4'h0; wr_data = 8'h00; wr_en = 1'b1;
        #2;
        check("R7 pad_out before write edge", 32'(pad_out), 32'h000A5);
        @(negedge clk);
        wr_en = 1'b0;
        check("R7 pad_out after write edge", 32'(pad_out), 32'h00000);

        // R8: pin sampling through the synchroniser
        pad_in = 20'hABCDE;
        repeat (3) @(negedge clk);
        rd(4'h0, r); check("R8 pins 7:0", 32'(r), 32'hDE);
        rd(4'h1, r); check("R8 pins 15:8", 32'(r), 32'hBC);
        rd(4'h2, r); check("R8 R3 pins 19:16", 32'(r), 32'h0A);
        @(negedge clk);
        pad_in = 20'h12345;
        addr = 4'h0; rd_en = 1'b1;
        @(negedge clk);
        check("R8 read one edge after change", 32'(rd_data), 32'hDE);
        @(negedge clk);
        check("R8 read two edges after change", 32'(rd_data), 32'hDE);
        @(negedge clk);
        rd_en = 1'b0;
        check("R8 read three edges after change", 32'(rd_data), 32'h45);
        repeat (2) @(negedge clk);
        check("R8 rd_data holds", 32'(rd_data), 32'h45);

        // R1: reset in mid-run restores the idle state
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pad_oe after second reset", 32'(pad_oe), 32'h0);
        rd(4'h6, r); check("R1 dir 7:0 after second reset", 32'(r), 32'hFF);
        rd(4'h9, r); check("R1 mode after second reset", 32'(r), 32'h03);
        wr(4'h9, 8'h00);
        check("R1 R5 data all ones after reset", 32'(pad_out), 32'hFFFFF);

        finish_run();
    end
endmodule